// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This unit sits beside a load/store pipeline. For every memory request it works out the effective data address and, where the addressing mode requires it, the new value of the pointer register pair. It reads the six pointer bytes from an external register file and supports five addressing modes:

- a 16-bit absolute address;
- a plain pointer;
- a pointer plus a small unsigned offset;
- a pointer decremented before use;
- a pointer incremented after use.

The register file storage, the memory access and the instruction decode all belong to neighbouring blocks.

A request is presented with `req_valid` high. One clock later the result appears on the registered outputs with `out_valid` high. The register file applies `ptr_wb_data` to pair `ptr_wb_sel` when `ptr_wb_en` is high. Combinations that are not allowed raise `illegal` and never write back.

Top module: `dspace_agu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `ptr_wb_en`, `illegal`, `eff_addr`, `ptr_wb_data` and `ptr_wb_sel` are all zero.
- R2: With mode code 0 (absolute), `eff_addr` equals `abs_addr` over the full 0x0000..0xFFFF range. `ptr_sel` is ignored, `illegal` is 0 and `ptr_wb_en` is 0.
- R3: Byte k of `ptr_bytes` (bits 8k+7:8k) holds register 26+k. The pairs are X = {byte1,byte0}, Y = {byte3,byte2} and Z = {byte5,byte4}, with the low byte in the even register. `ptr_sel` codes are 0 = X, 1 = Y and 2 = Z.
- R4: With mode code 1 (plain pointer), `eff_addr` equals the selected pair and `ptr_wb_en` is 0.
- R5: With mode code 2 (offset), Y or Z plus the zero-extended 6-bit `offset` (0..63) gives `eff_addr`, wrapping modulo 2^16. `ptr_wb_en` is 0.
- R6: Mode code 2 with X selected sets `illegal` to 1, `ptr_wb_en` to 0 and `eff_addr` to 0.
- R7: With mode code 3 (decrement before use), `eff_addr` and `ptr_wb_data` both equal the pair minus one, wrapping 0x0000 to 0xFFFF. `ptr_wb_en` is 1 and `ptr_wb_sel` equals `ptr_sel`.
- R8: With mode code 4 (increment after use), `eff_addr` is the old pair and `ptr_wb_data` is the pair plus one, wrapping 0xFFFF to 0x0000. `ptr_wb_en` is 1 and `ptr_wb_sel` equals `ptr_sel`.
- R9: Mode codes 5..7, and `ptr_sel` code 3 in any mode other than mode 0, set `illegal` to 1, `ptr_wb_en` to 0 and `eff_addr` to 0.
- R10: The results of a request taken at a clock edge appear after that edge with `out_valid` high. After an edge with `req_valid` low, `out_valid` and `ptr_wb_en` are 0, and `eff_addr`, `ptr_wb_data` and `illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code |
| ptr_sel | input | 2 | Pointer pair select |
| abs_addr | input | 16 | Absolute address for mode 0 |
| offset | input | 6 | Unsigned offset for mode 2 |
| ptr_bytes | input | 48 | Registers 26..31, byte k = register 26+k |
| out_valid | output | 1 | Result registers hold a fresh result |
| eff_addr | output | 16 | Effective data address |
| ptr_wb_data | output | 16 | New pointer pair value |
| ptr_wb_en | output | 1 | Write `ptr_wb_data` to the selected pair |
| ptr_wb_sel | output | 2 | Pair to write back |
| illegal | output | 1 | Request combination not allowed |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, a 6-bit offset and three pointer pairs. These values make the real wrap points reachable. A decrement from 0x0000, an increment from 0xFFFF, an offset that carries out of the top bit and the maximum offset of 63 are each hit exactly. Because the reserved select code 3 exists with three pairs, the out-of-range pair path is exercised as well.

// File: rtl/dagu_pkg.sv
package dagu_pkg;
  typedef enum logic [2:0] {
    AM_ABS     = 3'd0,
    AM_PTR     = 3'd1,
    AM_OFS     = 3'd2,
    AM_DEC_PRE = 3'd3,
    AM_INC_PST = 3'd4
  } amode_e;

  localparam logic [1:0] PAIR_X = 2'd0;
endpackage

// File: rtl/dagu_pair_pick.sv
module dagu_pair_pick #(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  parameter int SW   = 2
) (
  input  logic [NPTR*AW-1:0] ptr_flat,
  input  logic [SW-1:0]      sel,
  output logic [AW-1:0]      ptr,
  output logic               sel_ok
);
  logic [AW-1:0] pairs [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_pair
    assign pairs[g] = ptr_flat[g*AW +: AW];
  end

  always_comb begin
    ptr    = '0;
    sel_ok = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SW'(i)) begin
        ptr    = pairs[i];
        sel_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dagu_calc.sv
module dagu_calc
  import dagu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic [2:0]    mode,
  input  logic          sel_ok,
  input  logic          sel_is_x,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] abs_addr,
  input  logic [DW-1:0] offset,
  output logic [AW-1:0] eff,
  output logic [AW-1:0] wbd,
  output logic          wben,
  output logic          ill
);
  localparam int PADW = AW - DW;

  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_inc;

  assign ofs_ext = {{PADW{1'b0}}, offset};
  assign ptr_dec = ptr - AW'(1);
  assign ptr_inc = ptr + AW'(1);

  always_comb begin
    eff  = '0;
    wbd  = '0;
    wben = 1'b0;
    ill  = 1'b0;
    unique case (mode)
      AM_ABS: eff = abs_addr;
      AM_PTR: begin
        if (sel_ok) eff = ptr;
        else        ill = 1'b1;
      end
      AM_OFS: begin
        if (sel_ok && !sel_is_x) eff = ptr + ofs_ext;
        else                     ill = 1'b1;
      end
      AM_DEC_PRE: begin
        if (sel_ok) begin
          eff  = ptr_dec;
          wbd  = ptr_dec;
          wben = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      AM_INC_PST: begin
        if (sel_ok) begin
          eff  = ptr;
          wbd  = ptr_inc;
          wben = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      default: ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/dagu_out_stage.sv
module dagu_out_stage #(
  parameter int AW = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_eff,
  input  logic [AW-1:0] in_wbd,
  input  logic          in_wben,
  input  logic [SW-1:0] in_wbsel,
  input  logic          in_ill,
  output logic          q_valid,
  output logic [AW-1:0] q_eff,
  output logic [AW-1:0] q_wbd,
  output logic          q_wben,
  output logic [SW-1:0] q_wbsel,
  output logic          q_ill
);
  logic [AW-1:0] eff_d;
  logic [AW-1:0] wbd_d;
  logic [SW-1:0] wbsel_d;
  logic          ill_d;
  logic          wben_d;

  always_comb begin
    eff_d   = q_eff;
    wbd_d   = q_wbd;
    wbsel_d = q_wbsel;
    ill_d   = q_ill;
    wben_d  = 1'b0;
    if (in_valid) begin
      eff_d   = in_eff;
      wbd_d   = in_wbd;
      wbsel_d = in_wbsel;
      ill_d   = in_ill;
      wben_d  = in_wben;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_eff   <= '0;
      q_wbd   <= '0;
      q_wben  <= 1'b0;
      q_wbsel <= '0;
      q_ill   <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_eff   <= eff_d;
      q_wbd   <= wbd_d;
      q_wben  <= wben_d;
      q_wbsel <= wbsel_d;
      q_ill   <= ill_d;
    end
  end

  // R6
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_wben && q_ill));

  // R10
  wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wben |-> q_valid);
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
  import dagu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 6,
  parameter int NPTR = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          mode,
  input  logic [1:0]          ptr_sel,
  input  logic [AW-1:0]       abs_addr,
  input  logic [DW-1:0]       offset,
  input  logic [NPTR*AW-1:0]  ptr_bytes,
  output logic                out_valid,
  output logic [AW-1:0]       eff_addr,
  output logic [AW-1:0]       ptr_wb_data,
  output logic                ptr_wb_en,
  output logic [1:0]          ptr_wb_sel,
  output logic                illegal
);
  localparam int SW = 2;

  logic [AW-1:0] cur_ptr;
  logic          sel_ok;
  logic [AW-1:0] c_eff;
  logic [AW-1:0] c_wbd;
  logic          c_wben;
  logic          c_ill;

  dagu_pair_pick #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_pick (
    .ptr_flat (ptr_bytes),
    .sel      (ptr_sel),
    .ptr      (cur_ptr),
    .sel_ok   (sel_ok)
  );

  dagu_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode     (mode),
    .sel_ok   (sel_ok),
    .sel_is_x (ptr_sel == PAIR_X),
    .ptr      (cur_ptr),
    .abs_addr (abs_addr),
    .offset   (offset),
    .eff      (c_eff),
    .wbd      (c_wbd),
    .wben     (c_wben),
    .ill      (c_ill)
  );

  dagu_out_stage #(.AW(AW), .SW(SW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_eff   (c_eff),
    .in_wbd   (c_wbd),
    .in_wben  (c_wben),
    .in_wbsel (ptr_sel),
    .in_ill   (c_ill),
    .q_valid  (out_valid),
    .q_eff    (eff_addr),
    .q_wbd    (ptr_wb_data),
    .q_wben   (ptr_wb_en),
    .q_wbsel  (ptr_wb_sel),
    .q_ill    (illegal)
  );

  // R2
  abs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == AM_ABS) |=>
      (out_valid && !ptr_wb_en && !illegal && eff_addr == $past(abs_addr)));

  // R6
  ofs_on_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == AM_OFS && ptr_sel == PAIR_X) |=> (illegal && !ptr_wb_en));

  // R7
  dec_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == AM_DEC_PRE && ptr_sel != 2'd3) |=>
      (ptr_wb_en && ptr_wb_data == eff_addr && ptr_wb_sel == $past(ptr_sel)));

  // R8
  inc_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == AM_INC_PST && ptr_sel != 2'd3) |=>
      (ptr_wb_en && ptr_wb_data == AW'(eff_addr + AW'(1))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !ptr_wb_en && $stable(eff_addr)));
endmodule

// File: tb/dspace_agu_test.sv
`timescale 1ns/1ps
module dspace_agu_test;
  localparam int VW = 109;
  localparam int NV = 17;
  localparam logic [47:0] P1 = 48'hFFFF_8000_1234;
  localparam logic [47:0] P2 = 48'h00FF_FFC5_0000;

  // fields: mode, sel, abs, offset, ptrs, exp_eff, exp_wbd, exp_wben, exp_ill
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 2'd3, 16'hABCD, 6'd0,  P1, 16'hABCD, 16'h0000, 1'b0, 1'b0}, // R2
    {3'd0, 2'd0, 16'hFFFF, 6'd5,  P2, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R2
    {3'd1, 2'd0, 16'h0000, 6'd0,  P1, 16'h1234, 16'h0000, 1'b0, 1'b0}, // R3 R4
    {3'd1, 2'd1, 16'h0000, 6'd0,  P1, 16'h8000, 16'h0000, 1'b0, 1'b0}, // R3 R4
    {3'd1, 2'd2, 16'h0000, 6'd0,  P1, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R3 R4
    {3'd2, 2'd1, 16'h0000, 6'd63, P1, 16'h803F, 16'h0000, 1'b0, 1'b0}, // R5
    {3'd2, 2'd2, 16'h0000, 6'd1,  P1, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R5 wrap
    {3'd2, 2'd0, 16'h0000, 6'd4,  P1, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R6
    {3'd3, 2'd0, 16'h0000, 6'd0,  P2, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0}, // R7 wrap
    {3'd3, 2'd2, 16'h0000, 6'd0,  P1, 16'hFFFE, 16'hFFFE, 1'b1, 1'b0}, // R7
    {3'd4, 2'd2, 16'h0000, 6'd0,  P1, 16'hFFFF, 16'h0000, 1'b1, 1'b0}, // R8 wrap
    {3'd4, 2'd1, 16'h0000, 6'd0,  P2, 16'hFFC5, 16'hFFC6, 1'b1, 1'b0}, // R8
    {3'd5, 2'd1, 16'h0000, 6'd0,  P1, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R9
    {3'd1, 2'd3, 16'h0000, 6'd0,  P1, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R9
    {3'd3, 2'd3, 16'h0000, 6'd0,  P1, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R9
    {3'd2, 2'd1, 16'h0000, 6'd58, P2, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R5
    {3'd2, 2'd2, 16'h0000, 6'd0,  P2, 16'h00FF, 16'h0000, 1'b0, 1'b0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic [15:0] abs_addr;
  logic [5:0]  offset;
  logic [47:0] ptr_bytes;
  logic        out_valid;
  logic [15:0] eff_addr;
  logic [15:0] ptr_wb_data;
  logic        ptr_wb_en;
  logic [1:0]  ptr_wb_sel;
  logic        illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dspace_agu uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .ptr_sel(ptr_sel), .abs_addr(abs_addr), .offset(offset),
    .ptr_bytes(ptr_bytes), .out_valid(out_valid), .eff_addr(eff_addr),
    .ptr_wb_data(ptr_wb_data), .ptr_wb_en(ptr_wb_en),
    .ptr_wb_sel(ptr_wb_sel), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; mode = '0; ptr_sel = '0;
    abs_addr = '0; offset = '0; ptr_bytes = P1;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; mode = 3'd3;
    @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 ptr_wb_en", 32'(ptr_wb_en), 0);
    chk("R1 eff_addr", 32'(eff_addr), 0);
    chk("R1 illegal", 32'(illegal), 0);
    chk("R1 wb_data", 32'(ptr_wb_data), 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      req_valid = 1'b1;
      mode      = v[108:106];
      ptr_sel   = v[105:104];
      abs_addr  = v[103:88];
      offset    = v[87:82];
      ptr_bytes = v[81:34];
      step();
      chk($sformatf("R10 valid v%0d", i), 32'(out_valid), 1);
      chk($sformatf("R2-9 eff v%0d", i), 32'(eff_addr), 32'(v[33:18]));
      chk($sformatf("R6-9 wben v%0d", i), 32'(ptr_wb_en), 32'(v[1]));
      chk($sformatf("R9 ill v%0d", i), 32'(illegal), 32'(v[0]));
      if (v[1]) begin
        chk($sformatf("R7 R8 wbd v%0d", i), 32'(ptr_wb_data), 32'(v[17:2]));
        chk($sformatf("R7 R8 wbsel v%0d", i), 32'(ptr_wb_sel), 32'(v[105:104]));
      end
    end

    // R10: idle cycle after a write-back request holds values, drops strobes
    req_valid = 1'b1; mode = 3'd4; ptr_sel = 2'd0; ptr_bytes = P1;
    step();
    chk("R8 eff X", 32'(eff_addr), 32'h1234);
    chk("R8 wbd X", 32'(ptr_wb_data), 32'h1235);
    req_valid = 1'b0; mode = 3'd0; abs_addr = 16'h5555;
    step();
    chk("R10 idle valid", 32'(out_valid), 0);
    chk("R10 idle wben", 32'(ptr_wb_en), 0);
    chk("R10 idle eff hold", 32'(eff_addr), 32'h1234);
    chk("R10 idle wbd hold", 32'(ptr_wb_data), 32'h1235);

    // R2: back-to-back absolute requests, pointer select ignored
    req_valid = 1'b1; mode = 3'd0; ptr_sel = 2'd3; abs_addr = 16'h0000;
    step();
    chk("R2 abs zero", 32'(eff_addr), 0);
    chk("R2 abs ill", 32'(illegal), 0);
    abs_addr = 16'h8001;
    step();
    chk("R2 abs b2b", 32'(eff_addr), 32'h8001);

    // R1: asynchronous reset clears outputs mid-run
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async eff", 32'(eff_addr), 0);
    chk("R1 async valid", 32'(out_valid), 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule